// File: doc/BRIEF.md
# Chainable Serial-Load DAC Code Register

This block is the digital front end of a 12-bit voltage-output converter with a serial input. A host drives three wires: a serial clock, a serial data line and an active-low select/load line. The block samples all three with its own system clock through a synchronizer. While the select line is low, it shifts one bit into a shift register on each rising serial clock edge, most significant bit first. When the select line rises, it copies the shift register into a holding register. The holding register drives the parallel converter code. A one-cycle strobe marks each copy.

The last stage of the shift register drives a serial output. Several copies can share the serial clock and the select line, with each serial output wired to the serial input of the next copy. A long frame then fills every device, and a single rising edge of the select line updates all of them together. The block gates the serial clock internally with the select line, and it keeps that gate's known quirk: if the serial clock is already high when select falls, the gated clock rises at that moment and one extra bit is shifted in.

Top module: `chain_dac_front`

## Requirements
- R1: During and just after power-on reset, the code output is 0, the serial output is 0 and the update strobe is 0.
- R2: A frame of 12 bits sent most significant bit first, each taken on a rising serial clock edge while select is low, appears as the code after select rises. Bit 11 of the code is the first bit sent.
- R3: The code changes only when select rises. At that point it takes the shift register contents, and it holds its value while bits are being shifted in.
- R4: The update strobe is high for exactly one system clock per rising edge of select, in the same cycle that the new code first appears.
- R5: While select is high, serial clock and data activity changes neither the serial output nor the shift register. A following frame with no clock edges therefore reloads the unchanged word.
- R6: The serial output is the last shift stage. Sampled just before each rising serial clock edge of a 12-bit frame, it gives the previously held word, bit 11 first.
- R7: If the serial clock is high when select falls, one extra bit (the serial data value at that moment) is shifted in. A following 11-clock frame then places that bit in code bit 11.
- R8: When more than 12 bits are sent in one frame, only the last 12 reach the code. The earlier bits leave through the serial output.
- R9: Each pin change takes effect at the third system clock edge after it has been sampled. The code, the serial output and the strobe follow a cycle-exact model on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_clk | input | 1 | Serial clock pin (asynchronous) |
| ser_din | input | 1 | Serial data in pin (asynchronous) |
| ser_sel_n | input | 1 | Active-low select/load pin (asynchronous) |
| ser_dout | output | 1 | Last shift stage, for chaining |
| dac_code | output | 12 | Held converter code |
| dac_update | output | 1 | One-cycle strobe when the code loads |

## Verification
The bench sends exact 12-bit frames of mixed, all-ones and all-zeros words. These separate the bit order and the end values, and the serial output read during each frame separates a correct chain from an off-by-one shift. A 16-bit frame shows whether excess bits are dropped from the front. A 0-clock frame sent after serial clock activity with select high shows whether that activity disturbed the shift register. A frame opened with the serial clock high shows whether the extra shift is present, because a code of 0x800 arises only if it is. A behavioural model in the bench, fed from the sampled pins, is compared with all three outputs on every clock and pins down the synchronizer latency.

// File: rtl/cdac_pkg.sv
package cdac_pkg;
   // Pin indices inside the synchronized pin vector
   localparam int PIN_CLK  = 0;
   localparam int PIN_DIN  = 1;
   localparam int PIN_SELN = 2;
   localparam int NUM_PINS = 3;

   // Idle (reset) level of each pin: serial clock low, data low, select high
   localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b100;

   typedef struct packed {
      logic sel_n;
      logic din;
      logic clk;
   } ser_pins_t;
endpackage

// File: rtl/cdac_sync.sv
module cdac_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cdac_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cdac_edge.sv
module cdac_edge #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic rise,
   output logic fall
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RESET_VAL;
      else        prev <= sig;
   end

   assign rise = sig & ~prev;
   assign fall = ~sig & prev;
endmodule

// File: rtl/cdac_shift.sv
module cdac_shift #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             bit_in,
   output logic [WIDTH-1:0] word,
   output logic             bit_out
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cdac_shift: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sr <= '0;
      else if (step) sr <= {sr[WIDTH-2:0], bit_in};
   end

   assign word    = sr;
   assign bit_out = sr[WIDTH-1];
endmodule

// File: rtl/cdac_hold.sv
module cdac_hold #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             loaded
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= '0;
         loaded <= 1'b0;
      end else begin
         loaded <= load;
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/chain_dac_front.sv
module chain_dac_front #(
   parameter int DAC_BITS    = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_clk,
   input  logic                ser_din,
   input  logic                ser_sel_n,
   output logic                ser_dout,
   output logic [DAC_BITS-1:0] dac_code,
   output logic                dac_update
);
   import cdac_pkg::*;

   generate
      if (DAC_BITS < 2) begin : g_bad_bits
         $error("chain_dac_front: DAC_BITS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("chain_dac_front: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NUM_PINS-1:0] pins_raw;
   logic [NUM_PINS-1:0] pins_s;
   ser_pins_t           pin;

   assign pins_raw[PIN_CLK]  = ser_clk;
   assign pins_raw[PIN_DIN]  = ser_din;
   assign pins_raw[PIN_SELN] = ser_sel_n;

   // One synchronizer per pin, each resetting to the pin's idle level
   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_sync
         cdac_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(PIN_IDLE[i])
         ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_async(pins_raw[i]),
            .q_sync (pins_s[i])
         );
      end
   endgenerate

   assign pin = ser_pins_t'(pins_s);

   // Serial clock gated by select: rising gate level means a shift.
   // Gate rises also when select falls while serial clock is high.
   logic gate_clk;
   logic shift_step;
   logic gate_fall_unused;
   logic load_step;
   logic sel_fall_unused;

   assign gate_clk = pin.clk & ~pin.sel_n;

   cdac_edge #(.RESET_VAL(1'b0)) u_gate_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (gate_clk),
      .rise (shift_step),
      .fall (gate_fall_unused)
   );

   cdac_edge #(.RESET_VAL(1'b1)) u_sel_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (pin.sel_n),
      .rise (load_step),
      .fall (sel_fall_unused)
   );

   logic [DAC_BITS-1:0] shift_word;

   cdac_shift #(.WIDTH(DAC_BITS)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (shift_step),
      .bit_in (pin.din),
      .word   (shift_word),
      .bit_out(ser_dout)
   );

   cdac_hold #(.WIDTH(DAC_BITS)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_step),
      .d     (shift_word),
      .q     (dac_code),
      .loaded(dac_update)
   );

   logic unused_ok;
   assign unused_ok = &{1'b0, gate_fall_unused, sel_fall_unused};
endmodule

// File: rtl/chain_dac_front_chk.sv
module chain_dac_front_chk #(
   parameter int W    = 12,
   parameter int SYNC = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ser_clk,
   input logic         ser_sel_n,
   input logic         ser_dout,
   input logic [W-1:0] dac_code,
   input logic         dac_update
);
   localparam int LAT  = SYNC + 1;
   localparam int LATP = SYNC + 2;

   // R1: reset state
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_state: assert (dac_code == '0 && !ser_dout && !dac_update)
            else $error("R1 reset state violated");
      end
   end

   // R4: the strobe never lasts two cycles
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      dac_update |=> !dac_update);

   // R3: the code moves only together with the strobe
   a_r3_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_update |-> $stable(dac_code));

   // R3: a strobe is always caused by a rising select pin
   a_r3_update_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      dac_update |-> ($past(ser_sel_n, LAT) && !$past(ser_sel_n, LATP)));

   // R5: with select high over the relevant window, the serial output holds
   a_r5_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ser_sel_n, LAT) && $past(ser_sel_n, LATP)) |-> $stable(ser_dout));

   logic unused_ok;
   assign unused_ok = &{1'b0, ser_clk};
endmodule

bind chain_dac_front chain_dac_front_chk #(.W(DAC_BITS), .SYNC(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ser_clk   (ser_clk),
   .ser_sel_n (ser_sel_n),
   .ser_dout  (ser_dout),
   .dac_code  (dac_code),
   .dac_update(dac_update)
);

// File: tb/tb_chain_dac_front.sv
`timescale 1ns/1ps
module tb_chain_dac_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_din = 1'b0;
   logic        ser_sel_n = 1'b1;
   logic        ser_dout;
   logic [11:0] dac_code;
   logic        dac_update;

   int checks = 0;
   int errors = 0;
   int upd_cnt = 0;
   bit done = 0;

   always #10 clk = ~clk;  // 50 MHz

   chain_dac_front dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ser_sel_n(ser_sel_n), .ser_dout(ser_dout), .dac_code(dac_code),
      .dac_update(dac_update)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
      end
   endtask

   // ---- behavioural reference: pins seen at edge t act at edge t+2 ----
   bit q1c, q1d, q1s, q2c, q2d, q2s, q3c, q3d, q3s;
   int m_sr, m_code, m_upd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sr = 0; m_code = 0; m_upd = 0;
         q1c = 0; q1d = 0; q1s = 1;
         q2c = 0; q2d = 0; q2s = 1;
         q3c = 0; q3d = 0; q3s = 1;
      end else begin
         m_upd = 0;
         if ((q2c && !q2s) && !(q3c && !q3s))
            m_sr = ((m_sr << 1) | int'(q2d)) & 12'hFFF;
         if (q2s && !q3s) begin
            m_code = m_sr;
            m_upd = 1;
         end
         q3c = q2c; q3d = q2d; q3s = q2s;
         q2c = q1c; q2d = q1d; q2s = q1s;
         q1c = ser_clk; q1d = ser_din; q1s = ser_sel_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R9 code vs model", dac_code, m_code);
         check("R9 dout vs model", ser_dout, m_sr[11]);
         check("R9 strobe vs model", dac_update, m_upd);
         if (dac_update) upd_cnt++;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Shift n bits of w (MSB first) with select already low;
   // seen[i] is the serial output just before the rising edge of bit i.
   task automatic shift_bits(input logic [15:0] w, input int n, output logic [15:0] seen);
      seen = '0;
      for (int i = n - 1; i >= 0; i--) begin
         ser_din = w[i];
         ser_clk = 1'b0;
         wait_cyc(4);
         seen[i] = ser_dout;
         ser_clk = 1'b1;
         wait_cyc(4);
      end
      ser_clk = 1'b0;
      wait_cyc(4);
   endtask

   task automatic frame(input logic [15:0] w, input int n, output logic [15:0] seen);
      ser_sel_n = 1'b0;
      wait_cyc(4);
      shift_bits(w, n, seen);
      ser_sel_n = 1'b1;
      wait_cyc(6);
   endtask

   initial begin
      logic [15:0] seen;
      int u0;
      wait_cyc(5);
      // R1
      check("R1 code at reset", dac_code, 0);
      check("R1 dout at reset", ser_dout, 0);
      check("R1 strobe at reset", dac_update, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      check("R1 code after release", dac_code, 0);

      // R2 / R6 / R4: mixed word
      u0 = upd_cnt;
      frame(16'h0ABC, 12, seen);
      check("R2 code 0xABC", dac_code, 12'hABC);
      check("R6 dout shows reset word", seen[11:0], 12'h000);
      check("R4 one strobe per load", upd_cnt - u0, 1);

      frame(16'h05A4, 12, seen);
      check("R2 code 0x5A4", dac_code, 12'h5A4);
      check("R6 dout shows previous word", seen[11:0], 12'hABC);

      // R5: clock activity with select high is ignored
      for (int k = 0; k < 5; k++) begin
         ser_din = k[0];
         ser_clk = 1'b1; wait_cyc(4);
         ser_clk = 1'b0; wait_cyc(4);
         check("R5 dout unchanged while deselected", ser_dout, 0);
      end
      check("R5 code unchanged while deselected", dac_code, 12'h5A4);
      u0 = upd_cnt;
      frame(16'h0000, 0, seen);
      check("R5 empty frame reloads untouched word", dac_code, 12'h5A4);
      check("R4 strobe on empty frame", upd_cnt - u0, 1);

      // R7: clock high at select fall gives an extra shift
      ser_din = 1'b1;
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_sel_n = 1'b0;
      wait_cyc(4);
      ser_clk = 1'b0;
      wait_cyc(4);
      shift_bits(16'h0000, 11, seen);
      ser_sel_n = 1'b1;
      wait_cyc(6);
      check("R7 extra shift lands in bit 11", dac_code, 12'h800);

      // R8: 16-bit frame keeps the last 12
      frame(16'hF123, 16, seen);
      check("R8 last 12 bits kept", dac_code, 12'h123);
      check("R8 earlier word leaves on dout", seen[15:4], 12'h800);

      // R3: code held during shifting; boundary words
      ser_sel_n = 1'b0;
      wait_cyc(4);
      shift_bits(16'h0FFF, 12, seen);
      check("R3 code held while shifting", dac_code, 12'h123);
      ser_sel_n = 1'b1;
      wait_cyc(6);
      check("R2 code all ones", dac_code, 12'hFFF);
      frame(16'h0000, 12, seen);
      check("R2 code all zeros", dac_code, 12'h000);
      check("R6 dout shows all ones", seen[11:0], 12'hFFF);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule